// File: doc/BRIEF.md
# DE-Gated 8B/10B Symbol Encoder

This block sits on the transmit side of a single-lane serial link that carries its clock inside the data. On every clock cycle it takes one byte and a data-enable qualifier and registers one 10-bit symbol for the serializer. While the enable is high, the byte is coded as an 8B/10B data character. While the enable is low, the block sends the K28.5 comma instead. The comma gives the far end a pattern it can use to find symbol boundaries. The enable is the only control input. There is no sync input, no handshake and no back-pressure, so an upstream source can frame any kind of traffic just by dropping the enable in the gaps between words.

The byte splits into two parts. The low five bits go through a 5-bit to 6-bit code, and the high three bits go through a 3-bit to 4-bit code. Each sub-code has two forms, and the current running disparity picks between them. Running disparity is updated after the 6-bit part and again after the 4-bit part. Because of this, the number of ones minus the number of zeros on the line never drifts beyond one, and no more than five equal bits ever appear in a row.

Top module: `de_comma_encoder`

## Requirements
- R1: Reset (active-low `rst_n`) sets `sym_o` to 10'b1100000101 and sets running disparity to negative, so the first comma after reset is 10'b0011111010.
- R2: `sym_o` is registered. The symbol for the inputs sampled at rising edge N appears after edge N, and nothing passes from input to output within a cycle. Bit 9 of `sym_o` is line bit a (sent first) and bit 0 is line bit j (sent last), laid out as {a,b,c,d,e,i,f,g,h,j}.
- R3: While `de_i` is low, `byte_i` is ignored. The symbol is K28.5: 10'b0011111010 when running disparity is negative and 10'b1100000101 when it is positive. Either form flips running disparity.
- R4: While `de_i` is high, `sym_o[9:4]` is the 6-bit code of `byte_i[4:0]` and `sym_o[3:0]` is the 4-bit code of `byte_i[7:5]`. A data symbol never equals either K28.5 form.
- R5: Form choice: with negative disparity going into a sub-block, the form with more ones (or the balanced base form) is sent. With positive disparity, the complement is sent for unbalanced codes and for the two balanced codes that have alternate forms (6-bit code of value 7 and 4-bit code of value 3). Example: data byte 8'h00 at negative disparity gives 10'b1001110100.
- R6: Every symbol holds 4, 5 or 6 ones. A symbol with 6 ones leaves disparity positive, one with 4 ones leaves it negative, and one with 5 ones leaves it unchanged.
- R7: No run of more than five identical bits appears on the line, inside a symbol or across the boundary between symbols.
- R8: When the high bits equal 7, the alternate 4-bit code (0111 at negative disparity, 1000 at positive) replaces the primary one. This happens for low value 17, 18 or 20 at negative disparity and for low value 11, 13 or 14 at positive disparity. Examples: byte {3'd7,5'd17} at negative disparity gives 10'b1000110111, and byte {3'd7,5'd11} at positive disparity gives 10'b1101001000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| de_i | input | 1 | Data enable; low requests a comma |
| byte_i | input | 8 | Data byte, sampled when `de_i` is high |
| sym_o | output | 10 | Registered symbol, bit 9 sent first |

## Verification
A directed sweep of all 256 byte values is run from each starting disparity. This tells apart table errors in either form of every 6-bit and 4-bit code. Hand-picked bytes with known symbols check the alternate D.x.7 codes and the balanced codes that still swap form. A run of back-to-back commas then shows that disparity flips on every comma. Long stretches of random bytes with a random enable mix data and commas at both disparities. Each symbol is compared with a bench-side encoder, and the bench also checks the symbol's weight, the disparity sign and the run length across symbol boundaries.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    localparam int unsigned LO_W  = 5;
    localparam int unsigned HI_W  = 3;
    localparam int unsigned BYTE_W = LO_W + HI_W;
    localparam int unsigned LO_CW = LO_W + 1;
    localparam int unsigned HI_CW = HI_W + 1;
    localparam int unsigned SYM_W = LO_CW + HI_CW;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_e;

    localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;

    localparam logic [HI_CW-1:0] ALT7_NEG = 4'b0111;

    typedef struct packed {
        logic [SYM_W-1:0] sym;
        rd_e              rd;
    } enc_state_t;

    function automatic rd_e rd_flip(input rd_e r);
        return (r == RD_NEG) ? RD_POS : RD_NEG;
    endfunction

    // Negative-disparity form of the 6-bit code, written abcdei.
    function automatic logic [LO_CW-1:0] lo_code_neg(input logic [LO_W-1:0] x);
        logic [LO_CW-1:0] c;
        case (x)
            5'd0:  c = 6'b100111;
            5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;
            5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;
            5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;
            5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;
            5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;
            5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;
            5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;
            5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;
            5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;
            5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;
            5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;
            5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;
            5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;
            5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;
            5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;
            default: c = 6'b101011;
        endcase
        return c;
    endfunction

    // Negative-disparity form of the primary 4-bit code, written fghj.
    function automatic logic [HI_CW-1:0] hi_code_neg(input logic [HI_W-1:0] y);
        logic [HI_CW-1:0] c;
        case (y)
            3'd0: c = 4'b1011;
            3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;
            3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;
            3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;
            default: c = 4'b1110;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lenc_lo_sub.sv
module lenc_lo_sub
    import lenc_pkg::*;
(
    input  logic [LO_W-1:0]  x_i,
    input  rd_e              rd_i,
    output logic [LO_CW-1:0] code_o,
    output rd_e              rd_o
);

    localparam int unsigned LO_HALF = LO_CW / 2;
    localparam logic [LO_W-1:0] SWAP_VAL = 5'd7;

    logic [LO_CW-1:0] base;
    logic             balanced;
    logic             keep_base;

    always_comb begin
        base      = lo_code_neg(x_i);
        balanced  = ($countones(base) == LO_HALF);
        keep_base = (rd_i == RD_NEG) || (balanced && (x_i != SWAP_VAL));
        code_o    = keep_base ? base : ~base;
        rd_o      = balanced ? rd_i : rd_flip(rd_i);
    end

endmodule

// File: rtl/lenc_hi_sub.sv
module lenc_hi_sub
    import lenc_pkg::*;
(
    input  logic [HI_W-1:0]  y_i,
    input  logic [LO_W-1:0]  x_i,
    input  rd_e              rd_i,
    output logic [HI_CW-1:0] code_o,
    output rd_e              rd_o
);

    localparam int unsigned HI_HALF = HI_CW / 2;
    localparam logic [HI_W-1:0] SWAP_VAL = 3'd3;
    localparam logic [HI_W-1:0] SEVEN    = 3'd7;

    logic             alt_neg;
    logic             alt_pos;
    logic             use_alt;
    logic [HI_CW-1:0] base;
    logic             balanced;
    logic             keep_base;

    always_comb begin
        alt_neg   = (x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20);
        alt_pos   = (x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14);
        use_alt   = (y_i == SEVEN) &&
                    (((rd_i == RD_NEG) && alt_neg) || ((rd_i == RD_POS) && alt_pos));
        base      = use_alt ? ALT7_NEG : hi_code_neg(y_i);
        balanced  = ($countones(base) == HI_HALF);
        keep_base = (rd_i == RD_NEG) || (balanced && (y_i != SWAP_VAL));
        code_o    = keep_base ? base : ~base;
        rd_o      = balanced ? rd_i : rd_flip(rd_i);
    end

endmodule

// File: rtl/de_comma_encoder.sv
module de_comma_encoder
    import lenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              de_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [SYM_W-1:0]  sym_o
);

    enc_state_t       state_d;
    enc_state_t       state_q;

    logic [LO_CW-1:0] lo_code;
    logic [HI_CW-1:0] hi_code;
    rd_e              lo_rd;
    rd_e              hi_rd;

    lenc_lo_sub u_lo (
        .x_i    (byte_i[LO_W-1:0]),
        .rd_i   (state_q.rd),
        .code_o (lo_code),
        .rd_o   (lo_rd)
    );

    lenc_hi_sub u_hi (
        .y_i    (byte_i[BYTE_W-1:LO_W]),
        .x_i    (byte_i[LO_W-1:0]),
        .rd_i   (lo_rd),
        .code_o (hi_code),
        .rd_o   (hi_rd)
    );

    always_comb begin
        state_d = state_q;
        if (de_i) begin
            state_d.sym = {lo_code, hi_code};
            state_d.rd  = hi_rd;
        end else begin
            state_d.sym = (state_q.rd == RD_NEG) ? COMMA_NEG : COMMA_POS;
            state_d.rd  = rd_flip(state_q.rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sym <= COMMA_POS;
            state_q.rd  <= RD_NEG;
        end else begin
            state_q <= state_d;
        end
    end

    assign sym_o = state_q.sym;

endmodule

// File: rtl/de_comma_encoder_chk.sv
module de_comma_encoder_chk
    import lenc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             de_i,
    input logic [SYM_W-1:0] sym_o,
    input rd_e              rd_q
);

    localparam int unsigned MAX_RUN = 5;
    localparam int unsigned WIN_W   = SYM_W + MAX_RUN;

    logic             armed_q;
    logic [SYM_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            prev_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            prev_q  <= sym_o;
        end
    end

    function automatic logic run_ok(input logic [WIN_W-1:0] w);
        int run;
        logic ok;
        run = 1;
        ok  = 1'b1;
        for (int i = WIN_W - 2; i >= 0; i--) begin
            run = (w[i] == w[i+1]) ? run + 1 : 1;
            if (run > MAX_RUN) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sym_o) >= 4) && ($countones(sym_o) <= 6)); // R6

    AST_RD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(sym_o) == 6) -> (rd_q == RD_POS)) &&
        (($countones(sym_o) == 4) -> (rd_q == RD_NEG))); // R6

    AST_RD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ((rd_q != $past(rd_q)) == ($countones(sym_o) != 5))); // R6

    AST_COMMA_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(de_i)) |->
        (sym_o == ((rd_q == RD_POS) ? COMMA_NEG : COMMA_POS))); // R3

    AST_DATA_NO_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(de_i)) |-> ((sym_o != COMMA_NEG) && (sym_o != COMMA_POS))); // R4

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> run_ok({prev_q[MAX_RUN-1:0], sym_o})); // R7

endmodule

bind de_comma_encoder de_comma_encoder_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .de_i  (de_i),
    .sym_o (sym_o),
    .rd_q  (state_q.rd)
);

// File: tb/test_de_comma_encoder.sv
module test_de_comma_encoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       de_i;
    logic [7:0] byte_i;
    logic [9:0] sym_o;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cycles = 0;
    logic m_rdpos;
    int   run_len;
    logic last_bit;

    always #10 clk = ~clk;

    de_comma_encoder i_de_comma_encoder (
        .clk    (clk),
        .rst_n  (rst_n),
        .de_i   (de_i),
        .byte_i (byte_i),
        .sym_o  (sym_o)
    );

    function automatic logic [5:0] t6(input logic [4:0] x);
        case (x)
            5'd0: return 6'b100111;   5'd1: return 6'b011101;
            5'd2: return 6'b101101;   5'd3: return 6'b110001;
            5'd4: return 6'b110101;   5'd5: return 6'b101001;
            5'd6: return 6'b011001;   5'd7: return 6'b111000;
            5'd8: return 6'b111001;   5'd9: return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] t4(input logic [2:0] y);
        case (y)
            3'd0: return 4'b1011;  3'd1: return 4'b1001;
            3'd2: return 4'b0101;  3'd3: return 4'b1100;
            3'd4: return 4'b1101;  3'd5: return 4'b1010;
            3'd6: return 4'b0110;  default: return 4'b1110;
        endcase
    endfunction

    function automatic int pop(input logic [9:0] v);
        int n = 0;
        for (int i = 0; i < 10; i++) n += int'(v[i]);
        return n;
    endfunction

    // Returns {disparity after, symbol}; bit 10 set means positive.
    function automatic logic [10:0] ref_enc(input logic de, input logic [7:0] b, input logic rdpos);
        logic [5:0] m6;
        logic [3:0] m4;
        logic       r;
        logic       alt;
        if (!de) return {~rdpos, (rdpos ? 10'b1100000101 : 10'b0011111010)};
        r  = rdpos;
        m6 = t6(b[4:0]);
        if (r && !((pop({4'b0, m6}) == 3) && (b[4:0] != 5'd7))) m6 = ~m6;
        if (pop({4'b0, m6}) != 3) r = ~r;
        alt = (b[7:5] == 3'd7) &&
              ((!r && (b[4:0] == 5'd17 || b[4:0] == 5'd18 || b[4:0] == 5'd20)) ||
               ( r && (b[4:0] == 5'd11 || b[4:0] == 5'd13 || b[4:0] == 5'd14)));
        m4 = alt ? 4'b0111 : t4(b[7:5]);
        if (r && !((pop({6'b0, m4}) == 2) && (b[7:5] != 3'd3))) m4 = ~m4;
        if (pop({6'b0, m4}) != 2) r = ~r;
        return {r, m6, m4};
    endfunction

    task automatic check(input logic ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic track_run(input logic [9:0] s);
        int worst = 0;
        for (int i = 9; i >= 0; i--) begin
            if (run_len > 0 && s[i] == last_bit) run_len++;
            else run_len = 1;
            last_bit = s[i];
            if (run_len > worst) worst = run_len;
        end
        check(worst <= 5, "R7 run length", 10'(worst), 10'd5);
    endtask

    // Called at a negedge: drive, let one rising edge pass, check at next negedge.
    task automatic step(input logic de, input logic [7:0] b, input logic use_lit,
                        input logic [9:0] lit, input string lit_req);
        logic [10:0] e;
        logic        rd_before;
        de_i   = de;
        byte_i = b;
        rd_before = m_rdpos;
        e = ref_enc(de, b, m_rdpos);
        @(negedge clk);
        check(sym_o == e[9:0], de ? "R4 data symbol" : "R3 comma symbol", sym_o, e[9:0]);
        if (use_lit) check(sym_o == lit, lit_req, sym_o, lit);
        check(pop(sym_o) >= 4 && pop(sym_o) <= 6, "R6 symbol weight", sym_o, e[9:0]);
        if (pop(sym_o) == 6) check(e[10] == 1'b1, "R6 sign after heavy symbol", sym_o, e[9:0]);
        if (pop(sym_o) == 4) check(e[10] == 1'b0, "R6 sign after light symbol", sym_o, e[9:0]);
        if (de) begin
            if (!rd_before) check(pop({4'b0, sym_o[9:4]}) >= 3, "R5 form at negative", sym_o, e[9:0]);
            else            check(pop({4'b0, sym_o[9:4]}) <= 3, "R5 form at positive", sym_o, e[9:0]);
        end
        track_run(sym_o);
        m_rdpos = e[10];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n  = 1'b0;
        de_i   = 1'b0;
        byte_i = 8'h00;
        m_rdpos  = 1'b0;
        run_len  = 0;
        last_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value of the symbol
        check(sym_o == 10'b1100000101, "R1 reset symbol", sym_o, 10'b1100000101);
        track_run(sym_o);

        // R2: no path from input to output inside a cycle
        de_i   = 1'b1;
        byte_i = 8'hFF;
        #3;
        check(sym_o == 10'b1100000101, "R2 registered output", sym_o, 10'b1100000101);
        de_i = 1'b0;
        #2;
        // R1: first comma after reset has negative-disparity form
        step(1'b0, 8'hA5, 1'b1, 10'b0011111010, "R1 first comma");
        step(1'b0, 8'h3C, 1'b1, 10'b1100000101, "R3 comma at positive");
        step(1'b1, 8'h00, 1'b1, 10'b1001110100, "R5 D.0.0 at negative");
        step(1'b1, {3'd7, 5'd17}, 1'b1, 10'b1000110111, "R8 alternate at negative");
        step(1'b0, 8'h00, 1'b1, 10'b1100000101, "R3 comma at positive");
        step(1'b0, 8'h00, 1'b1, 10'b0011111010, "R3 comma at negative");
        step(1'b1, {3'd7, 5'd11}, 1'b1, 10'b1101001000, "R8 alternate at positive");

        // Full byte sweeps from both disparities
        for (int pass = 0; pass < 2; pass++) begin
            if (m_rdpos == pass[0]) step(1'b0, 8'h00, 1'b0, 10'b0, "");
            for (int v = 0; v < 256; v++) step(1'b1, 8'(v), 1'b0, 10'b0, "");
        end

        // Back-to-back commas with data on the byte bus (R3: byte ignored)
        for (int k = 0; k < 8; k++) step(1'b0, 8'($urandom), 1'b0, 10'b0, "");

        // Random traffic
        for (int k = 0; k < 4000; k++)
            step(($urandom % 4) != 0, 8'($urandom), 1'b0, 10'b0, "");

        finish_run();
    end

endmodule